// File: doc/BRIEF.md
# Debug Serial Packet Responder

This block is the target-side serial port of an on-chip debug unit. An external development host runs a synchronous serial clock and exchanges 17-bit packets with it, full-duplex. Each packet has a flag bit in bit 16 and a 16-bit word in bits 15 to 0. Inbound, the flag is a control bit that the host must send as 0. Outbound, it is a status bit. The status bit and a few special data values together make up a small set of response codes.

On the core side, the block delivers each good inbound word as a one-cycle strobe. It builds the next outbound packet from a response-kind selector and a read-data input. Two conditions override that selection with a not-ready reply: a memory access that is still pending, and the recovery gap of processor clocks that follows every completed transfer.

The serial clock and serial data are synchronized into the processor clock domain. An inbound packet with its control bit set produces no strobe. Instead it is answered with the illegal-command code on the next packet that is not preempted.

Top module: `dbg_serial_port`

## Requirements
- R1: Packets are 17 bits and travel most significant bit first. Inbound bits are taken at rising serial-clock edges. The outbound bit changes only after falling serial-clock edges, so the first bit is on `sdo_o` before the first rising edge.
- R2: When an inbound packet with bit 16 equal to 0 completes outside the recovery gap, `cmd_valid_o` pulses for exactly one clock and `cmd_word_o` carries bits 15:0.
- R3: An inbound packet with bit 16 equal to 1 produces no strobe. The next packet that is not preempted by not-ready returns status 1 with data 0xFFFF. The packet after that returns to the selected response.
- R4: `rsp_kind_i` encodes the reply as follows:
  - 0: status 0 with `rsp_data_i`
  - 1: status 0 with 0xFFFF (accepted)
  - 2: status 1 with 0x0001 (bus error)
  - 3: status 1 with 0xFFFF (illegal)
- R5: While `mem_pending_i` is 1, the outbound packet is status 1 with 0x0000 (not ready). The inbound word is still delivered.
- R6: A transfer whose first rising edge falls within RECOVER_CLKS (32) clocks of the previous completion returns not-ready. Its inbound word is discarded, with no strobe and no illegal flag. A transfer after the gap is served normally.
- R7: Not-ready takes priority over a pending illegal-command report, and that report stays pending.
- R8: During reset, `cmd_valid_o` is 0 and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, idle low, asynchronous |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| cmd_word_o | output | 16 | Last accepted inbound word |
| cmd_valid_o | output | 1 | One-cycle strobe for `cmd_word_o` |
| rsp_kind_i | input | 2 | Response selector (R4 encoding) |
| rsp_data_i | input | 16 | Read data for kind 0 |
| mem_pending_i | input | 1 | Memory access in progress |

## Verification
The assertions take for granted that each serial-clock level lasts several processor clocks, so the synchronizer yields one clean edge pulse per host edge. They also assume `sdi_i` is stable around each rising edge. The bench meets both by holding every serial-clock half period for six clocks, changing `sdi_i` only at falling edges, and keeping the response inputs and `mem_pending_i` still for the whole of each transfer. The gap cases use idle times well inside or well outside the 32-clock window, so no result depends on synchronizer latency.

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int WORD_W       = 16,
  parameter int RECOVER_CLKS = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  input  logic [1:0]        rsp_kind_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  input  logic              mem_pending_i
);
  localparam int PKT_W = WORD_W + 1;
  localparam int CNT_W = $clog2(PKT_W + 1);
  localparam int GAP_W = $clog2(RECOVER_CLKS + 1);
  localparam logic [PKT_W-1:0] NOT_READY = {1'b1, {WORD_W{1'b0}}};
  localparam logic [PKT_W-1:0] ACCEPTED  = {1'b0, {WORD_W{1'b1}}};
  localparam logic [PKT_W-1:0] BUS_ERR   = {1'b1, WORD_W'(1)};
  localparam logic [PKT_W-1:0] BAD_CMD   = {1'b1, {WORD_W{1'b1}}};

  logic [SYNC_STAGES:0]   sclk_sh;
  logic [SYNC_STAGES-1:0] sdi_sh;
  logic [CNT_W-1:0]       bitcnt;
  logic [GAP_W-1:0]       gap_cnt;
  logic [WORD_W-1:0]      rx_q;
  logic [PKT_W-1:0]       tx_q, rsp_sel, rx_next;
  logic                   gap_hit, ill_pend, ill_sent;
  logic                   rise_p, fall_p, done_p, start_p, idle_load, busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sh <= '0;
      sdi_sh  <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-1:0], sclk_i};
      sdi_sh  <= {sdi_sh[SYNC_STAGES-2:0], sdi_i};
    end

  assign rise_p    =  sclk_sh[SYNC_STAGES-1] & ~sclk_sh[SYNC_STAGES];
  assign fall_p    = ~sclk_sh[SYNC_STAGES-1] &  sclk_sh[SYNC_STAGES];
  assign start_p   = rise_p && bitcnt == '0;
  assign done_p    = rise_p && bitcnt == CNT_W'(PKT_W - 1);
  assign idle_load = bitcnt == '0 && !rise_p;
  assign rx_next   = {rx_q, sdi_sh[SYNC_STAGES-1]};
  assign busy      = mem_pending_i || gap_cnt != '0;
  assign sdo_o     = tx_q[PKT_W-1];

  always_comb begin
    if (busy)          rsp_sel = NOT_READY;
    else if (ill_pend) rsp_sel = BAD_CMD;
    else
      case (rsp_kind_i)
        2'd0:    rsp_sel = {1'b0, rsp_data_i};
        2'd1:    rsp_sel = ACCEPTED;
        2'd2:    rsp_sel = BUS_ERR;
        default: rsp_sel = BAD_CMD;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      rx_q   <= '0;
    end else if (rise_p) begin
      rx_q   <= rx_next[WORD_W-1:0];
      bitcnt <= done_p ? '0 : bitcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_q     <= '0;
      ill_sent <= 1'b0;
    end else if (idle_load) begin
      tx_q     <= rsp_sel;
      ill_sent <= !busy && ill_pend;
    end else if (fall_p && bitcnt != '0) begin
      tx_q     <= {tx_q[PKT_W-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                gap_cnt <= '0;
    else if (done_p)           gap_cnt <= GAP_W'(RECOVER_CLKS);
    else if (gap_cnt != '0)    gap_cnt <= gap_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gap_hit <= 1'b0;
    else if (start_p) gap_hit <= gap_cnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ill_pend <= 1'b0;
    else if (start_p && ill_sent) ill_pend <= 1'b0;
    else if (done_p && !gap_hit && rx_next[PKT_W-1]) ill_pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
    end else begin
      cmd_valid_o <= done_p && !gap_hit && !rx_next[PKT_W-1];
      if (done_p && !gap_hit && !rx_next[PKT_W-1]) cmd_word_o <= rx_next[WORD_W-1:0];
    end
endmodule

module dbg_serial_port_chk #(
  parameter int WORD_W       = 16,
  parameter int RECOVER_CLKS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_o,
  input logic              mem_pending_i,
  input logic              sdo_o,
  input logic              rise_p,
  input logic              fall_p,
  input logic              done_p,
  input logic [$clog2(WORD_W+2)-1:0]     bitcnt,
  input logic [$clog2(RECOVER_CLKS+1)-1:0] gap_cnt,
  input logic [WORD_W:0]   tx_q,
  input logic [WORD_W:0]   rx_next
);
  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R1
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt != '0 && !fall_p) |=> $stable(sdo_o));
  // R6
  gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> gap_cnt == RECOVER_CLKS);
  // R5
  not_ready_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == '0 && !rise_p && (mem_pending_i || gap_cnt != '0))
      |=> tx_q == {1'b1, {WORD_W{1'b0}}});
  // R3
  illegal_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_p && rx_next[WORD_W]) |=> !cmd_valid_o);
endmodule

bind dbg_serial_port dbg_serial_port_chk #(
  .WORD_W(WORD_W), .RECOVER_CLKS(RECOVER_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o),
  .mem_pending_i(mem_pending_i), .sdo_o(sdo_o), .rise_p(rise_p),
  .fall_p(fall_p), .done_p(done_p), .bitcnt(bitcnt), .gap_cnt(gap_cnt),
  .tx_q(tx_q), .rx_next(rx_next)
);

// File: tb/test_dbg_serial_port.sv
module test_dbg_serial_port;
  localparam int HALF = 6;
  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, mem_pend = 0;
  logic [1:0]  kind = 0;
  logic [15:0] rdata = 0;
  logic        sdo, cvalid;
  logic [15:0] cword;
  int checks = 0, fails = 0;
  logic [15:0] stbq[$];
  bit ill_model = 0;

  always #2 clk = ~clk;

  dbg_serial_port i_dbg_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .cmd_word_o(cword), .cmd_valid_o(cvalid), .rsp_kind_i(kind),
    .rsp_data_i(rdata), .mem_pending_i(mem_pend));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && cvalid) begin
      if (stbq.size() == 0) check(0, "R2 unexpected strobe", {16'h0, cword}, 32'h0);
      else begin
        logic [15:0] e;
        e = stbq.pop_front();
        check(cword == e, "R2 strobe word", {16'h0, cword}, {16'h0, e});
      end
    end

  function automatic logic [16:0] expected_rsp(bit gap);
    if (gap || mem_pend) return 17'h10000;
    if (ill_model)       return 17'h1FFFF;
    case (kind)
      2'd0: return {1'b0, rdata};
      2'd1: return 17'h0FFFF;
      2'd2: return 17'h10001;
      default: return 17'h1FFFF;
    endcase
  endfunction

  task automatic xfer(input logic [16:0] w, input bit gap, input string req);
    logic [16:0] got, exp;
    bit stb;
    exp = expected_rsp(gap);
    stb = !gap && !w[16];
    if (!gap && !mem_pend && ill_model) ill_model = 0;
    if (!gap && w[16]) ill_model = 1;
    if (stb) stbq.push_back(w[15:0]);
    for (int i = 16; i >= 0; i--) begin
      sdi = w[i];
      repeat (HALF) @(negedge clk);
      got[i] = sdo;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    check(got == exp, req, {15'h0, got}, {15'h0, exp});
    check(stbq.size() == 0, {req, " strobe count"}, stbq.size(), 0);
    stbq.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cvalid == 0, "R8 valid in reset", cvalid, 0);
    check(sdo == 0, "R8 sdo in reset", sdo, 0);
    rst_n = 1;
    idle(40);
    kind = 1;                     xfer(17'h01234, 0, "R2 R4 accepted code");
    idle(40); kind = 0; rdata = 16'hA5C3;
                                  xfer(17'h08001, 0, "R1 R4 read data");
    idle(40); kind = 2;           xfer(17'h05555, 0, "R4 bus error code");
    idle(40); kind = 3;           xfer(17'h0AAAA, 0, "R4 illegal code");
    idle(40); kind = 1;           xfer(17'h10F0F, 0, "R3 control bit set");
                                  xfer(17'h03C3C, 1, "R6 R7 gap preempts");
    idle(40);                     xfer(17'h02222, 0, "R3 illegal reported");
    idle(40);                     xfer(17'h04444, 0, "R3 illegal cleared");
    idle(40); mem_pend = 1;       xfer(17'h07777, 0, "R5 memory pending");
    mem_pend = 0;
    idle(40); kind = 0; rdata = 16'h0000;
                                  xfer(17'h0FFFE, 0, "R1 R6 after gap");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule